// File: doc/BRIEF.md
# Two-Level Super-Tile Address Generator

This block turns a pixel coordinate on a 32-bit-per-pixel surface into the byte address of that pixel in a tiled memory layout. The smallest unit is a square tile of 4x4 pixels. In the two-level layout, tiles are collected into groups of 2 tiles wide by 4 tiles high. Groups are then collected 8 wide by 4 high into a 64x64-pixel super-tile. A 2-bit mode selects between plain tile order and super-tile order. A second mode bit spreads alternate tiles over two pipes, each with its own base address, and halves the offset seen from each base.

A requester presents one coordinate per cycle together with the surface width in super-tiles, the mode and the two base addresses. The address and a pipe-select bit come back one cycle later with a valid flag. Requests may be issued back to back. Both bases must be 64-byte aligned, and the surface must be a whole number of super-tiles across.

Top module: `stile_addr_gen`

## Requirements
- R1: `out_valid_o` is high in exactly the cycle after a cycle with `req_valid_i` high, and low otherwise; a new request is accepted on every cycle.
- R2: While `rst` is high, a clock edge clears `out_valid_o`, `addr_o` and `pipe_o` to zero.
- R3: Mode 2'b00 (plain tiled): the tile index is (y/4)·(W·16) + x/4, where W is `width_st_i`, and the address is `base0_i` + 64·index + in-tile byte.
- R4: Mode 2'b01 (super-tiled): the tile index is 256·(super-tile row·W + super-tile column) + 8·(group index, row-major over 8x4 groups) + (tile index within the 2-wide, 4-high group, row-major), and the address is `base0_i` + 64·index + in-tile byte.
- R5: With 64-byte-aligned bases, `addr_o[5:0]` equals 4·((y mod 4)·4 + x mod 4) in every mode.
- R6: Mode bit 1 set (2'b10 split plain, 2'b11 split super): `pipe_o` is bit 0 of the tile index of the layout named by mode bit 0, and the address is built from `base1_i` when it is 1 and from `base0_i` when it is 0.
- R7: In split modes, the address is the selected base + 64·(tile index / 2) + in-tile byte.
- R8: In modes 2'b00 and 2'b01, `pipe_o` is 0.
- R9: A cycle without a request leaves `addr_o` and `pipe_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Coordinate request |
| x_i | input | 16 | Pixel column |
| y_i | input | 16 | Pixel row |
| width_st_i | input | 8 | Surface width in super-tiles |
| mode_i | input | 2 | Bit 0: super-tile order; bit 1: two-pipe split |
| base0_i | input | 32 | First base address, 64-byte aligned |
| base1_i | input | 32 | Second base address, used by split modes |
| out_valid_o | output | 1 | Result valid |
| addr_o | output | 32 | Byte address |
| pipe_o | output | 1 | Selected pipe |

## Verification
Two functions coincide in every split-mode result: choosing the pipe and halving the offset both depend on the same tile index. A fault in either one therefore shows up in the same output sample. The bench sweeps every pixel of a 128x128 surface in all four modes with back-to-back requests. This makes consecutive tiles change pipe on consecutive cycles. For each result, the pipe bit, the base it selects and the halved offset are each judged against a tile ordering that the bench builds by counting through nested loops. Idle cycles are placed among the requests, so the hold behaviour is checked right next to a fresh result.

// File: rtl/stile_pkg.sv
package stile_pkg;
  typedef enum logic [1:0] {
    MODE_TILED       = 2'b00,
    MODE_SUPER       = 2'b01,
    MODE_SPLIT_TILED = 2'b10,
    MODE_SPLIT_SUPER = 2'b11
  } stile_mode_e;

  // log2 of geometry: tile side, group width/height in tiles, super-tile groups across/down
  localparam int TILE_LOG2   = 2;
  localparam int GRP_W_LOG2  = 1;
  localparam int GRP_H_LOG2  = 2;
  localparam int SUP_GW_LOG2 = 3;
  localparam int SUP_GH_LOG2 = 2;
  localparam int BPP_LOG2    = 2;
endpackage

// File: rtl/stile_tile_index.sv
module stile_tile_index
  import stile_pkg::*;
#(
  parameter int CW    = 16,
  parameter int WST_W = 8,
  parameter int IDX_W = 26
) (
  input  logic [CW-1:0]    tx_i,
  input  logic [CW-1:0]    ty_i,
  input  logic [WST_W-1:0] width_st_i,
  input  logic             super_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam int SUP_TX_LOG2 = GRP_W_LOG2 + SUP_GW_LOG2;
  localparam int SUP_TY_LOG2 = GRP_H_LOG2 + SUP_GH_LOG2;
  localparam int SUP_T_LOG2  = SUP_TX_LOG2 + SUP_TY_LOG2;

  logic [IDX_W-1:0] row_pitch;
  logic [IDX_W-1:0] idx_plain;
  logic [IDX_W-1:0] sup_num;
  logic [SUP_T_LOG2-1:0] in_sup;
  logic [IDX_W-1:0] idx_super;

  always_comb begin
    row_pitch = IDX_W'(width_st_i) << SUP_TX_LOG2;
    idx_plain = IDX_W'(ty_i) * row_pitch + IDX_W'(tx_i);
    sup_num   = IDX_W'(ty_i >> SUP_TY_LOG2) * IDX_W'(width_st_i)
              + IDX_W'(tx_i >> SUP_TX_LOG2);
    // group row, group column, row in group, column in group
    in_sup    = {ty_i[SUP_TY_LOG2-1:GRP_H_LOG2], tx_i[SUP_TX_LOG2-1:GRP_W_LOG2],
                 ty_i[GRP_H_LOG2-1:0], tx_i[GRP_W_LOG2-1:0]};
    idx_super = (sup_num << SUP_T_LOG2) | IDX_W'(in_sup);
    idx_o     = super_i ? idx_super : idx_plain;
  end
endmodule

// File: rtl/stile_fold.sv
module stile_fold
  import stile_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 26,
  parameter int BYTE_W = 6
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              split_i,
  input  logic [ADDR_W-1:0] base0_i,
  input  logic [ADDR_W-1:0] base1_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              pipe_o
);
  logic [IDX_W-1:0]  slot;
  logic [ADDR_W-1:0] base_sel;

  always_comb begin
    pipe_o   = split_i & idx_i[0];
    slot     = split_i ? (idx_i >> 1) : idx_i;
    base_sel = pipe_o ? base1_i : base0_i;
    addr_o   = base_sel + {slot, byte_i};
  end
endmodule

// File: rtl/stile_addr_gen.sv
module stile_addr_gen
  import stile_pkg::*;
#(
  parameter int CW     = 16,
  parameter int WST_W  = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic [CW-1:0]     x_i,
  input  logic [CW-1:0]     y_i,
  input  logic [WST_W-1:0]  width_st_i,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] base0_i,
  input  logic [ADDR_W-1:0] base1_i,
  output logic              out_valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              pipe_o
);
  localparam int BYTE_W = 2 * TILE_LOG2 + BPP_LOG2;
  localparam int IDX_W  = ADDR_W - BYTE_W;

  stile_mode_e mode;
  logic [CW-1:0]     tx, ty;
  logic [BYTE_W-1:0] tile_byte;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] addr_nxt;
  logic              pipe_nxt;

  always_comb begin
    mode      = stile_mode_e'(mode_i);
    tx        = x_i >> TILE_LOG2;
    ty        = y_i >> TILE_LOG2;
    tile_byte = {y_i[TILE_LOG2-1:0], x_i[TILE_LOG2-1:0], {BPP_LOG2{1'b0}}};
  end

  stile_tile_index #(.CW(CW), .WST_W(WST_W), .IDX_W(IDX_W)) u_index (
    .tx_i       (tx),
    .ty_i       (ty),
    .width_st_i (width_st_i),
    .super_i    (mode == MODE_SUPER || mode == MODE_SPLIT_SUPER),
    .idx_o      (idx)
  );

  stile_fold #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BYTE_W(BYTE_W)) u_fold (
    .idx_i   (idx),
    .byte_i  (tile_byte),
    .split_i (mode == MODE_SPLIT_TILED || mode == MODE_SPLIT_SUPER),
    .base0_i (base0_i),
    .base1_i (base1_i),
    .addr_o  (addr_nxt),
    .pipe_o  (pipe_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o <= 1'b0;
      addr_o      <= '0;
      pipe_o      <= 1'b0;
    end else begin
      out_valid_o <= req_valid_i;
      if (req_valid_i) begin
        addr_o <= addr_nxt;
        pipe_o <= pipe_nxt;
      end
    end
  end
endmodule

// File: rtl/stile_addr_chk.sv
module stile_addr_chk #(
  parameter int CW     = 16,
  parameter int WST_W  = 8,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid_i,
  input logic [CW-1:0]     x_i,
  input logic [CW-1:0]     y_i,
  input logic [WST_W-1:0]  width_st_i,
  input logic [1:0]        mode_i,
  input logic [ADDR_W-1:0] base0_i,
  input logic [ADDR_W-1:0] base1_i,
  input logic              out_valid_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              pipe_o
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid_i |=> out_valid_o);
  assert_valid_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !req_valid_i |=> !out_valid_o);
  assert_reset_clear_R2: assert property (@(posedge clk)
    rst |=> (!out_valid_o && addr_o == '0 && !pipe_o));
  assert_tile_byte_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && base0_i[5:0] == 6'd0 && base1_i[5:0] == 6'd0)
    |=> addr_o[5:0] == {$past(y_i[1:0]), $past(x_i[1:0]), 2'b00});
  // alternate tiles across: parity of the tile index equals tile-column parity in both layouts
  assert_split_parity_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && mode_i[1]) |=> pipe_o == $past(x_i[2]));
  assert_nosplit_pipe_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && !mode_i[1]) |=> !pipe_o);
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !req_valid_i |=> ($stable(addr_o) && $stable(pipe_o)));
endmodule

bind stile_addr_gen stile_addr_chk #(.CW(CW), .WST_W(WST_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid_i (req_valid_i),
  .x_i         (x_i),
  .y_i         (y_i),
  .width_st_i  (width_st_i),
  .mode_i      (mode_i),
  .base0_i     (base0_i),
  .base1_i     (base1_i),
  .out_valid_o (out_valid_o),
  .addr_o      (addr_o),
  .pipe_o      (pipe_o)
);

// File: tb/stile_addr_gen_bench.sv
module stile_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [15:0] x, y;
  logic [7:0]  width_st;
  logic [1:0]  mode;
  logic [31:0] base0, base1;
  logic        out_valid;
  logic [31:0] addr;
  logic        pipe;

  int errs = 0;
  int checks = 0;
  int t_plain [32][32];
  int t_super [32][32];
  longint prev_addr = 0;
  int     prev_pipe = 0;

  always #4 clk = ~clk;

  stile_addr_gen u_stile_addr_gen (
    .clk (clk), .rst (rst), .req_valid_i (req_valid), .x_i (x), .y_i (y),
    .width_st_i (width_st), .mode_i (mode), .base0_i (base0), .base1_i (base1),
    .out_valid_o (out_valid), .addr_o (addr), .pipe_o (pipe)
  );

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  // one clock: drive a request (or idle), then check the registered result
  task automatic step(bit v, int px, int py, int md);
    int     tidx, pb, epipe;
    longint eaddr;
    string  tag;
    req_valid = v; x = 16'(px); y = 16'(py); mode = 2'(md);
    @(posedge clk); #2;
    check(out_valid == v, "R1 valid", longint'(out_valid), longint'(v));
    if (v) begin
      tidx = md[0] ? t_super[py/4][px/4] : t_plain[py/4][px/4];
      pb   = ((py % 4) * 4 + (px % 4)) * 4;
      if (md[1]) begin
        epipe = tidx % 2;
        eaddr = (epipe != 0 ? longint'(base1) : longint'(base0)) + longint'(tidx / 2) * 64 + pb;
        tag   = "R7 split address";
      end else begin
        epipe = 0;
        eaddr = longint'(base0) + longint'(tidx) * 64 + pb;
        tag   = md[0] ? "R4 super address" : "R3 tiled address";
      end
      eaddr = eaddr & 64'hFFFF_FFFF;
      check(longint'(addr) == eaddr, tag, longint'(addr), eaddr);
      check(int'(pipe) == epipe, md[1] ? "R6 pipe" : "R8 pipe", longint'(pipe), longint'(epipe));
      check(int'(addr[5:0]) == pb, "R5 tile byte", longint'(addr[5:0]), longint'(pb));
      prev_addr = eaddr;
      prev_pipe = epipe;
    end else begin
      check(longint'(addr) == prev_addr, "R9 hold addr", longint'(addr), prev_addr);
      check(int'(pipe) == prev_pipe, "R9 hold pipe", longint'(pipe), longint'(prev_pipe));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int cnt;
    // reference orderings built by counting through nested loops (128x128, 2 super-tiles across)
    cnt = 0;
    for (int ty = 0; ty < 32; ty++)
      for (int tx = 0; tx < 32; tx++) begin t_plain[ty][tx] = cnt; cnt++; end
    cnt = 0;
    for (int sy = 0; sy < 2; sy++)
      for (int sx = 0; sx < 2; sx++)
        for (int gy = 0; gy < 4; gy++)
          for (int gx = 0; gx < 8; gx++)
            for (int ry = 0; ry < 4; ry++)
              for (int rx = 0; rx < 2; rx++) begin
                t_super[sy*16 + gy*4 + ry][sx*16 + gx*2 + rx] = cnt;
                cnt++;
              end

    rst = 1'b1; req_valid = 1'b0; x = '0; y = '0; mode = '0; width_st = 8'd2;
    base0 = 32'h1000_0000; base1 = 32'h2000_0000;
    repeat (3) @(posedge clk);
    #2;
    check(!out_valid, "R2 reset valid", longint'(out_valid), 0);
    check(addr == 32'd0, "R2 reset addr", longint'(addr), 0);
    check(!pipe, "R2 reset pipe", longint'(pipe), 0);
    rst = 1'b0;

    for (int md = 0; md < 4; md++) begin
      base0 = 32'h1000_0000 + 32'(md) * 32'h0004_0000;
      base1 = 32'hFFFF_0000 - 32'(md) * 32'h0010_0000;
      for (int py = 0; py < 128; py++)
        for (int px = 0; px < 128; px++) begin
          if (((py * 128 + px) % 13) == 5) step(1'b0, 0, 0, md);
          step(1'b1, px, py, md);
        end
      step(1'b0, 3, 3, md);
    end
    summary();
    $finish;
  end
endmodule